// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block sits behind a dual-modulus prescaler in a frequency synthesizer loop and is clocked by the prescaler's output. It divides that clock further and controls the prescaler's modulus. Each division cycle is built from a main count SM and a swallow count SS. For the first SS prescaler periods of a cycle, the modulus-control output asks the prescaler to divide by P+1. For the remaining SM−SS periods it asks for P. Seen from the prescaler's input, the total ratio is therefore P·SM + SS, with P being 64 or 128. The prescaler chooses P; this block does not need to know it.

A configuration latch upstream presents new SM and SS values together with a one-cycle load strobe. The block keeps those values pending and switches to them only at the next cycle boundary, so no cycle is ever cut short or stretched by a reprogram. At every boundary the block emits one output pulse, one prescaler period wide, which feeds the phase detector. Legal values are SM from 4 to 2047 and SS from 0 to 127, with SS < SM.

Top module: `psw_divider`

## Requirements
- R1: While reset is held and directly after it, `div_pulse` and `mod_plus` are 0. The block then runs with the reset configuration SM=4, SS=0, so the first full interval between pulses is 4·P input cycles.
- R2: For a loaded configuration with 4 ≤ SM ≤ 2047, 0 ≤ SS ≤ 127 and SS < SM, consecutive rising edges of `div_pulse` are exactly P·SM + SS prescaler-input cycles apart, for both P=64 and P=128.
- R3: `mod_plus` is 1, requesting P+1, for exactly the first SS prescaler periods of each cycle and 0 for the rest. When SS=0 it stays 0 for the whole cycle.
- R4: Each division cycle lasts exactly SM prescaler-output periods, because the main counter steps on every prescaler pulse.
- R5: `div_pulse` is high for exactly one prescaler-output period per cycle. It rises on the same edge at which both counters reload.
- R6: A load strobe in the middle of a cycle leaves that cycle's length unchanged. The new SM and SS apply from the next cycle boundary, and the active configuration changes at no other time.
- R7: When several load strobes arrive within one cycle, the values of the last strobe are the ones applied at the boundary.
- R8: `mod_plus` can rise only on a cycle boundary, that is, on the edge where `div_pulse` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pre | input | 1 | Prescaler output clock; each rising edge is one prescaler pulse |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle strobe that captures cfg_main and cfg_swal |
| cfg_main | input | MAIN_W (11) | Main count SM |
| cfg_swal | input | SWAL_W (7) | Swallow count SS |
| mod_plus | output | 1 | Modulus control: 1 requests P+1, 0 requests P |
| div_pulse | output | 1 | One-period pulse per complete division cycle |

## Verification
Several internal faults show up directly at the ports:
- A wrong main count changes the number of prescaler periods between output pulses, so it is visible within one cycle.
- A swallow counter that is off by one, or one that stays active after reaching zero, changes how long `mod_plus` stays high. The P+1 count seen by the behavioural prescaler then moves the measured ratio by one or more input cycles on the very next cycle.
- A pending register that is applied too early shortens or lengthens the cycle that was in flight when the load strobe arrived. That error appears at the first boundary after the strobe.

The bench therefore measures the interval in prescaler-input cycles both before and after each reprogram. It also counts the periods per cycle and the P+1 periods per cycle.

// File: rtl/psw_pkg.sv
package psw_pkg;
  // modulus request driven towards the dual-modulus prescaler
  typedef enum logic {
    MOD_BASE = 1'b0,   // divide by P
    MOD_PLUS = 1'b1    // divide by P+1
  } mod_req_e;

  localparam int MIN_MAIN_COUNT = 4;
endpackage

// File: rtl/psw_cfg_shadow.sv
// Holds the active and pending division settings; pending values are
// promoted only on a cycle boundary.
module psw_cfg_shadow #(
  parameter int MAIN_W   = 11,
  parameter int SWAL_W   = 7,
  parameter int DEF_MAIN = 4,
  parameter int DEF_SWAL = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MAIN_W-1:0] main_in,
  input  logic [SWAL_W-1:0] swal_in,
  input  logic              boundary,
  output logic [MAIN_W-1:0] nxt_main,
  output logic [SWAL_W-1:0] nxt_swal,
  output logic [MAIN_W-1:0] act_main,
  output logic [SWAL_W-1:0] act_swal
);
  logic              pend_vld;
  logic [MAIN_W-1:0] pend_main;
  logic [SWAL_W-1:0] pend_swal;

  // value the counters take if this edge is a boundary; a strobe on the
  // boundary edge itself wins over an older pending value
  always_comb begin
    if (load) begin
      nxt_main = main_in;
      nxt_swal = swal_in;
    end else if (pend_vld) begin
      nxt_main = pend_main;
      nxt_swal = pend_swal;
    end else begin
      nxt_main = act_main;
      nxt_swal = act_swal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_main  <= MAIN_W'(DEF_MAIN);
      act_swal  <= SWAL_W'(DEF_SWAL);
      pend_main <= '0;
      pend_swal <= '0;
      pend_vld  <= 1'b0;
    end else if (boundary) begin
      act_main <= nxt_main;
      act_swal <= nxt_swal;
      pend_vld <= 1'b0;
    end else if (load) begin
      pend_main <= main_in;
      pend_swal <= swal_in;
      pend_vld  <= 1'b1;
    end
  end
endmodule

// File: rtl/psw_main_ctr.sv
// Main counter: steps on every prescaler pulse, flags the last period.
module psw_main_ctr #(
  parameter int MAIN_W   = 11,
  parameter int DEF_MAIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAIN_W-1:0] reload_val,
  output logic              expire,
  output logic [MAIN_W-1:0] main_rem
);
  assign expire = (main_rem == MAIN_W'(1));

  always_ff @(posedge clk) begin
    if (rst)         main_rem <= MAIN_W'(DEF_MAIN);
    else if (expire) main_rem <= reload_val;
    else             main_rem <= main_rem - MAIN_W'(1);
  end
endmodule

// File: rtl/psw_swal_ctr.sv
// Swallow counter: steps only while P+1 is requested; the request is
// registered from the counter's next value so it is ready for the period.
module psw_swal_ctr
  import psw_pkg::*;
#(
  parameter int SWAL_W   = 7,
  parameter int DEF_SWAL = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic [SWAL_W-1:0] reload_val,
  output logic [SWAL_W-1:0] swal_rem,
  output mod_req_e          mod_q
);
  logic [SWAL_W-1:0] swal_d;

  always_comb begin
    if (boundary)                 swal_d = reload_val;
    else if (swal_rem != '0)      swal_d = swal_rem - SWAL_W'(1);
    else                          swal_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      swal_rem <= SWAL_W'(DEF_SWAL);
      mod_q    <= (DEF_SWAL != 0) ? MOD_PLUS : MOD_BASE;
    end else begin
      swal_rem <= swal_d;
      mod_q    <= (swal_d != '0) ? MOD_PLUS : MOD_BASE;
    end
  end
endmodule

// File: rtl/psw_divider.sv
// Pulse-swallow divider top: total ratio P*SM + SS seen at prescaler input.
module psw_divider
  import psw_pkg::*;
#(
  parameter int MAIN_W   = 11,
  parameter int SWAL_W   = 7,
  parameter int DEF_MAIN = MIN_MAIN_COUNT,
  parameter int DEF_SWAL = 0
) (
  input  logic              clk_pre,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [MAIN_W-1:0] cfg_main,
  input  logic [SWAL_W-1:0] cfg_swal,
  output logic              mod_plus,
  output logic              div_pulse
);
  logic              expire;
  logic [MAIN_W-1:0] nxt_main, act_main, main_rem;
  logic [SWAL_W-1:0] nxt_swal, act_swal, swal_rem;
  mod_req_e          mod_q;

  psw_cfg_shadow #(
    .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .DEF_MAIN(DEF_MAIN), .DEF_SWAL(DEF_SWAL)
  ) u_shadow (
    .clk(clk_pre), .rst(rst), .load(cfg_load),
    .main_in(cfg_main), .swal_in(cfg_swal), .boundary(expire),
    .nxt_main(nxt_main), .nxt_swal(nxt_swal),
    .act_main(act_main), .act_swal(act_swal)
  );

  psw_main_ctr #(.MAIN_W(MAIN_W), .DEF_MAIN(DEF_MAIN)) u_main (
    .clk(clk_pre), .rst(rst), .reload_val(nxt_main),
    .expire(expire), .main_rem(main_rem)
  );

  psw_swal_ctr #(.SWAL_W(SWAL_W), .DEF_SWAL(DEF_SWAL)) u_swal (
    .clk(clk_pre), .rst(rst), .boundary(expire), .reload_val(nxt_swal),
    .swal_rem(swal_rem), .mod_q(mod_q)
  );

  // output pulse registered on the reload edge
  always_ff @(posedge clk_pre) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= expire;
  end

  assign mod_plus = (mod_q == MOD_PLUS);
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk #(
  parameter int MAIN_W = 11,
  parameter int SWAL_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              div_pulse,
  input logic              mod_plus,
  input logic [MAIN_W-1:0] main_rem,
  input logic [SWAL_W-1:0] swal_rem,
  input logic [MAIN_W-1:0] act_main,
  input logic [SWAL_W-1:0] act_swal
);
  a_r5_pulse_one_period: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  a_r8_mod_rise_on_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_plus) |-> div_pulse);

  a_r3_mod_follows_swallow: assert property (@(posedge clk) disable iff (rst)
    mod_plus == (swal_rem != '0));

  a_r6_cfg_only_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !div_pulse |-> ($stable(act_main) && $stable(act_swal)));

  a_r4_main_never_zero: assert property (@(posedge clk) disable iff (rst)
    main_rem != '0);
endmodule

bind psw_divider psw_divider_chk #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_chk (
  .clk(clk_pre), .rst(rst), .div_pulse(div_pulse), .mod_plus(mod_plus),
  .main_rem(main_rem), .swal_rem(swal_rem),
  .act_main(act_main), .act_swal(act_swal)
);

// File: tb/psw_divider_tb.sv
`timescale 1ns/1ps
module psw_divider_tb;
  localparam int MAIN_W = 11;
  localparam int SWAL_W = 7;

  logic              vco = 1'b0;
  logic              clk_pre = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_load = 1'b0;
  logic [MAIN_W-1:0] cfg_main = '0;
  logic [SWAL_W-1:0] cfg_swal = '0;
  logic              mod_plus, div_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  psw_divider #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_dut (
    .clk_pre(clk_pre), .rst(rst), .cfg_load(cfg_load),
    .cfg_main(cfg_main), .cfg_swal(cfg_swal),
    .mod_plus(mod_plus), .div_pulse(div_pulse)
  );

  always #5 vco = ~vco;   // 100 MHz prescaler input

  // behavioural dual-modulus prescaler: modulus latched one input cycle
  // after its output edge, once mod_plus has settled
  int p_now = 64;
  int plen  = 64;
  int pcnt  = 0;
  always @(posedge vco) begin
    if (pcnt >= plen - 1) pcnt = 0; else pcnt = pcnt + 1;
    if (pcnt == 1) plen = (mod_plus === 1'b1) ? p_now + 1 : p_now;
    clk_pre = (pcnt < 8);
  end

  // interval monitor in input cycles
  int vcnt = 0, rises = 0, last_stamp = 0;
  bit prev_pulse = 1'b0;
  always @(negedge vco) begin
    vcnt++;
    if (div_pulse === 1'b1 && !prev_pulse) begin
      rises++;
      last_stamp = vcnt;
    end
    prev_pulse = (div_pulse === 1'b1);
  end

  // per-cycle monitor in prescaler periods
  int hi_acc = 0, per_acc = 0, last_hi = -1, last_per = -1, wide_err = 0;
  bit pp_prev = 1'b0;
  always @(negedge clk_pre) begin
    if (!rst) begin
      if (div_pulse === 1'b1 && pp_prev) wide_err++;
      if (div_pulse === 1'b1 && !pp_prev) begin
        last_hi  = hi_acc;
        last_per = per_acc;
        hi_acc   = 0;
        per_acc  = 0;
      end
      per_acc++;
      if (mod_plus === 1'b1) hi_acc++;
      pp_prev = (div_pulse === 1'b1);
    end
  end

  function automatic int exp_ratio(int m, int s, int p);
    return p * m + s;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  int cur_m = 4, cur_s = 0, cur_p = 64;

  task automatic wait_rise(output int stamp);
    int r0 = rises;
    wait (rises > r0);
    stamp = last_stamp;
  endtask

  // program a configuration mid-cycle and measure old and new cycles
  task automatic apply(int m, int s, int p, bit decoy);
    int sa, sb, sc;
    bit same_p = (p == cur_p);
    wait_rise(sa);
    repeat (2) @(negedge clk_pre);
    p_now = p;
    if (decoy) begin
      cfg_main = MAIN_W'(4 + ($urandom % 60));
      cfg_swal = SWAL_W'($urandom % 4);
      cfg_load = 1'b1;
      @(negedge clk_pre);
    end
    cfg_main = MAIN_W'(m);
    cfg_swal = SWAL_W'(s);
    cfg_load = 1'b1;
    @(negedge clk_pre);
    cfg_load = 1'b0;
    cfg_main = MAIN_W'($urandom);   // not strobed: must not matter
    cfg_swal = SWAL_W'($urandom);
    wait_rise(sb);
    if (same_p) check("R6 cycle in flight keeps old ratio", sb - sa, exp_ratio(cur_m, cur_s, cur_p));
    wait_rise(sc);
    check(decoy ? "R7 last strobe wins, ratio" : "R2 ratio P*SM+SS", sc - sb, exp_ratio(m, s, p));
    repeat (2) @(negedge clk_pre);
    check("R3 periods at P+1 per cycle", last_hi, s);
    check("R4 prescaler periods per cycle", last_per, m);
    check("R5 pulse wider than one period", wide_err, 0);
    cur_m = m; cur_s = s; cur_p = p;
  endtask

  initial begin
    repeat (195000) @(posedge vco);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int sa, sb;
    void'($urandom(32'd20251));
    repeat (4) @(negedge clk_pre);
    check("R1 div_pulse in reset", int'(div_pulse), 0);
    check("R1 mod_plus in reset", int'(mod_plus), 0);
    rst = 1'b0;
    @(negedge clk_pre);
    check("R1 div_pulse after reset", int'(div_pulse), 0);
    check("R1 mod_plus after reset", int'(mod_plus), 0);
    wait_rise(sa);
    wait_rise(sb);
    check("R1 default ratio 4*P", sb - sa, exp_ratio(4, 0, 64));

    // directed corners
    apply(4, 3, 64, 1'b0);      // smallest SM, largest SS below it
    apply(4, 0, 64, 1'b0);      // SS=0 keeps mod_plus low
    apply(4, 0, 128, 1'b0);
    apply(128, 127, 64, 1'b0);  // largest swallow count
    apply(20, 19, 128, 1'b0);
    apply(40, 0, 128, 1'b0);
    apply(10, 5, 128, 1'b1);    // two strobes in one cycle

    // constrained random
    for (int i = 0; i < 8; i++) begin
      int m = 4 + int'($urandom % 21);
      int s = int'($urandom % m);
      int p = ($urandom % 2) ? 128 : 64;
      apply(m, s, p, ($urandom % 3) == 0);
    end
    finish_run();
  end
endmodule